// File: doc/BRIEF.md
# ADC Start/Read Handshake Sequencer

This block runs one conversion on an external 8-bit successive-approximation converter for each host request. It drives the converter's active-low select, start and output-enable strobes, and it watches the converter's active-low completion line. When the host pulses a start request, the sequencer lowers select and the start strobe, then releases the start strobe while select is still low. That rising edge is what launches the conversion. The sequencer then waits for the completion line to go low and runs a read cycle. It samples the byte while select and read are both low and reports it with a single-cycle done pulse.

The completion line is asynchronous to the system clock, so it passes through a two-flop synchroniser before the controller uses it. A conversion takes hundreds of microseconds, so the wait state has no fixed length. It is bounded only by a parameterised timeout. When the timeout expires, the sequencer raises a one-cycle error and goes back to idle without reading. A start request that arrives while a conversion is in progress is dropped.

Top module: `adcseq_top`

## Requirements
- R1: After reset, selN, startN and readN are high (1), and done, timeoutErr and busy are low.
- R2: For an accepted start, startN stays low for exactly WR_LOW_CYCLES clocks and then rises while selN is still low.
- R3: startN and readN are never low while selN is high.
- R4: readN stays low for exactly RD_LOW_CYCLES clocks per read, and a read begins only after the completion line has been seen low.
- R5: result equals the value on adcData during the final clock of the read window. done is high for exactly one clock, and result holds its value afterwards.
- R6: A startReq raised while busy is high launches no second start strobe.
- R7: If completion is not seen within TIMEOUT_CYCLES clocks of waiting, timeoutErr is high for exactly one clock, arriving WR_LOW_CYCLES+TIMEOUT_CYCLES+2 clocks after the start is accepted. No read takes place, and busy is low afterwards.
- R8: A conversion that completes late, but still inside the timeout window, is read normally.
- R9: eocN passes through two synchronising flops. readN falls in the fourth clock edge after the edge at which eocN goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Host conversion request, sampled each clock |
| eocN | input | 1 | Converter completion line, active low, asynchronous |
| adcData | input | DATA_W | Converter data pins |
| selN | output | 1 | Converter select, active low |
| startN | output | 1 | Converter start strobe, active low, conversion on rising edge |
| readN | output | 1 | Converter output enable, active low |
| busy | output | 1 | High while a conversion sequence is in progress |
| done | output | 1 | One-cycle pulse: result is valid |
| result | output | DATA_W | Captured conversion byte |
| timeoutErr | output | 1 | One-cycle pulse: conversion never completed |

## Verification
A controller stuck in the wrong state shows up within a few clocks as a strobe of the wrong width, a strobe outside select, or a read that comes before completion. The bench measures every strobe edge against select. A fault in the synchroniser or in the timeout counter moves the read or the error by a whole number of clocks. So the bench checks the exact clock distance from the completion edge to the read, and from the accepted start to the error. A capture made outside the read window returns the filler value that the bench converter model drives on the data pins when it is not enabled.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WRLO  = 3'd1,
    ST_WRHI  = 3'd2,
    ST_WAIT  = 3'd3,
    ST_RDLO  = 3'd4,
    ST_DONE  = 3'd5,
    ST_TOERR = 3'd6
  } seqState_t;

  typedef struct packed {
    logic loadWr;
    logic loadRd;
    logic clrTimer;
    logic capture;
  } ctrlStrobes_t;

endpackage

// File: rtl/adcseq_dpath.sv
module adcseq_dpath
  import adcseq_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int WR_LOW_CYCLES  = 2,
  parameter int RD_LOW_CYCLES  = 2,
  parameter int TIMEOUT_CYCLES = 20000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              eocN,
  input  logic [DATA_W-1:0] adcData,
  output logic              pulseDone,
  output logic              timerExpired,
  output logic              eocSeen,
  output logic [DATA_W-1:0] result
);

  localparam int MAX_PULSE = (WR_LOW_CYCLES > RD_LOW_CYCLES) ? WR_LOW_CYCLES : RD_LOW_CYCLES;
  localparam int CNT_W     = $clog2(MAX_PULSE + 1);
  localparam int TMR_W     = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_LOW_CYCLES - 1);
  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_LOW_CYCLES - 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYCLES - 1);

  logic [CNT_W-1:0] pulseCnt;
  logic [TMR_W-1:0] waitTimer;
  logic             eocMeta, eocStable;

  // two-flop synchroniser for the asynchronous completion line (R9)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eocMeta   <= 1'b1;
      eocStable <= 1'b1;
    end else begin
      eocMeta   <= eocN;
      eocStable <= eocMeta;
    end
  end
  assign eocSeen = !eocStable;

  // shared strobe-width counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 pulseCnt <= '0;
    else if (strobes.loadWr)   pulseCnt <= WR_LOAD;
    else if (strobes.loadRd)   pulseCnt <= RD_LOAD;
    else if (pulseCnt != '0)   pulseCnt <= pulseCnt - 1'b1;
  end
  assign pulseDone = (pulseCnt == '0);

  // wait-state timer, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   waitTimer <= '0;
    else if (strobes.clrTimer)   waitTimer <= '0;
    else if (waitTimer != TMR_LAST) waitTimer <= waitTimer + 1'b1;
  end
  assign timerExpired = (waitTimer == TMR_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                result <= '0;
    else if (strobes.capture) result <= adcData;
  end

  // R5: result only moves on a capture strobe
  assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.capture) |-> $stable(result));

  // R4: the strobe loads never collide
  assert_single_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.loadWr && strobes.loadRd));

endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startReq,
  input  logic         pulseDone,
  input  logic         timerExpired,
  input  logic         eocSeen,
  output ctrlStrobes_t strobes,
  output logic         selN,
  output logic         startN,
  output logic         readN,
  output logic         busy,
  output logic         done,
  output logic         timeoutErr
);

  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: if (startReq) begin
        strobes.loadWr = 1'b1;
        nextState      = ST_WRLO;
      end
      ST_WRLO: if (pulseDone) nextState = ST_WRHI;
      ST_WRHI: begin
        strobes.clrTimer = 1'b1;
        nextState        = ST_WAIT;
      end
      ST_WAIT: begin
        if (eocSeen) begin
          strobes.loadRd = 1'b1;
          nextState      = ST_RDLO;
        end else if (timerExpired) begin
          nextState = ST_TOERR;
        end
      end
      ST_RDLO: if (pulseDone) begin
        strobes.capture = 1'b1;
        nextState       = ST_DONE;
      end
      ST_DONE:  nextState = ST_IDLE;
      ST_TOERR: nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  assign selN       = !(state inside {ST_WRLO, ST_WRHI, ST_RDLO});
  assign startN     = (state != ST_WRLO);
  assign readN      = (state != ST_RDLO);
  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_DONE);
  assign timeoutErr = (state == ST_TOERR);

  // R6: a request during the wait changes nothing
  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && startReq && !eocSeen && !timerExpired) |=> (state == ST_WAIT));

  // R4: a read begins only after completion was seen
  assert_read_after_eoc_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readN) |-> $past(eocSeen));

  // R5: done lasts one cycle
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: error lasts one cycle and returns to idle
  assert_err_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |=> (!timeoutErr && !busy));

endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
  import adcseq_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int WR_LOW_CYCLES  = 2,
  parameter int RD_LOW_CYCLES  = 2,
  parameter int TIMEOUT_CYCLES = 20000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              eocN,
  input  logic [DATA_W-1:0] adcData,
  output logic              selN,
  output logic              startN,
  output logic              readN,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              timeoutErr
);

  ctrlStrobes_t strobes;
  logic pulseDone, timerExpired, eocSeen;

  adcseq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .pulseDone(pulseDone), .timerExpired(timerExpired), .eocSeen(eocSeen),
    .strobes(strobes), .selN(selN), .startN(startN), .readN(readN),
    .busy(busy), .done(done), .timeoutErr(timeoutErr)
  );

  adcseq_dpath #(
    .DATA_W(DATA_W), .WR_LOW_CYCLES(WR_LOW_CYCLES),
    .RD_LOW_CYCLES(RD_LOW_CYCLES), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .eocN(eocN), .adcData(adcData),
    .pulseDone(pulseDone), .timerExpired(timerExpired), .eocSeen(eocSeen),
    .result(result)
  );

  // R3: strobes only inside select
  assert_strobe_in_sel_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!startN || !readN) |-> !selN);

  // R2: start strobe released while select stays low
  assert_wr_release_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(startN) |-> !selN);

endmodule

// File: tb/test_adcseq_top.sv
module test_adcseq_top;

  localparam int WR = 3;
  localparam int RD = 2;
  localparam int TO = 200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic eocN = 1'b1;
  logic [7:0] adcData;
  logic selN, startN, readN, busy, done, timeoutErr;
  logic [7:0] result;

  int checks = 0;
  int fails = 0;

  // converter model state
  logic [7:0] adcValue = 8'h00;
  bit convEnable = 1'b1;
  int convDelay = 20;
  int convCnt = 0;
  bit convRun = 1'b0;
  int cyc = 0;
  int eocFallCyc = 0;
  int rdFallCyc = 0;
  logic wrPrev = 1'b1, rdPrev = 1'b1;
  int wrRun = 0, rdRun = 0;
  int lastWrWidth = 0, lastRdWidth = 0;
  int wrPulses = 0, rdPulses = 0;
  int selViol = 0, earlyRead = 0;

  always #4 clk = ~clk;

  assign adcData = (!selN && !readN) ? adcValue : 8'hEE;

  adcseq_top #(.DATA_W(8), .WR_LOW_CYCLES(WR), .RD_LOW_CYCLES(RD), .TIMEOUT_CYCLES(TO))
  i_adcseq_top (
    .clk(clk), .rstN(rstN), .startReq(startReq), .eocN(eocN), .adcData(adcData),
    .selN(selN), .startN(startN), .readN(readN), .busy(busy), .done(done),
    .result(result), .timeoutErr(timeoutErr)
  );

  // behavioural converter and pin monitor
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if ((!startN || !readN) && selN) selViol <= selViol + 1;
    if (!startN) wrRun <= wrRun + 1;
    if (!readN)  rdRun <= rdRun + 1;
    if (!wrPrev && startN) begin
      lastWrWidth <= wrRun;
      wrRun <= 0;
      wrPulses <= wrPulses + 1;
      if (!selN && convEnable) begin
        convRun <= 1'b1;
        convCnt <= convDelay;
      end
    end
    if (rdPrev && !readN) begin
      rdPulses  <= rdPulses + 1;
      rdFallCyc <= cyc;
      if (eocN) earlyRead <= earlyRead + 1;
      if (!selN) eocN <= 1'b1;
    end
    if (!rdPrev && readN) begin
      lastRdWidth <= rdRun;
      rdRun <= 0;
    end
    if (convRun) begin
      if (convCnt <= 1) begin
        convRun <= 1'b0;
        eocN <= 1'b0;
        eocFallCyc <= cyc;
      end else convCnt <= convCnt - 1;
    end
    wrPrev <= startN;
    rdPrev <= readN;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
  endtask

  // run one conversion and check its results
  task automatic runConversion(input logic [7:0] value, input int delay, input string req);
    int n = 0;
    int wr0 = wrPulses;
    int rd0 = rdPulses;
    adcValue = value;
    convDelay = delay;
    pulseStart();
    while (!done && !timeoutErr && n < TO + 100) begin @(negedge clk); n++; end
    check(done == 1'b1, req, done, 1);
    check(result == value, req, result, value);
    check(lastWrWidth == WR, "R2", lastWrWidth, WR);
    check(wrPulses - wr0 == 1, "R2", wrPulses - wr0, 1);
    check(rdPulses - rd0 == 1, "R4", rdPulses - rd0, 1);
    check(rdFallCyc - eocFallCyc == 4, "R9", rdFallCyc - eocFallCyc, 4);
    @(negedge clk);
    check(done == 1'b0, "R5", done, 0);
    check(result == value, "R5", result, value);
    check(lastRdWidth == RD, "R4", lastRdWidth, RD);
    check(selViol == 0 && earlyRead == 0, "R3", selViol + earlyRead, 0);
  endtask

  task automatic testReset();
    check(selN && startN && readN, "R1", {selN, startN, readN}, 7);
    check(!done && !timeoutErr && !busy, "R1", {done, timeoutErr, busy}, 0);
  endtask

  task automatic testBusyIgnore();
    int wr0 = wrPulses;
    adcValue = 8'h5A;
    convDelay = 40;
    pulseStart();
    repeat (10) @(negedge clk);
    startReq = 1'b1;
    repeat (5) @(negedge clk);
    startReq = 1'b0;
    while (!done && !timeoutErr) @(negedge clk);
    check(result == 8'h5A, "R6", result, 8'h5A);
    check(wrPulses - wr0 == 1, "R6", wrPulses - wr0, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic testTimeout();
    int n = 0;
    int rd0 = rdPulses;
    int doneSeen = 0;
    convEnable = 1'b0;
    @(negedge clk); startReq = 1'b1;
    @(posedge clk); n = 1;
    @(negedge clk); startReq = 1'b0;
    while (!timeoutErr && n < TO + 50) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (done) doneSeen++;
    end
    check(n == WR + TO + 2, "R7", n, WR + TO + 2);
    check(rdPulses == rd0 && doneSeen == 0, "R7", rdPulses - rd0 + doneSeen, 0);
    @(negedge clk);
    check(!timeoutErr && !busy, "R7", {timeoutErr, busy}, 0);
    convEnable = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    runConversion(8'hA5, 20, "R5");
    runConversion(8'h3C, 190, "R8");
    testBusyIgnore();
    testTimeout();
    runConversion(8'h00, 7, "R5");
    runConversion(8'hFF, 12, "R5");
    repeat (4) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule